// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings one or two ranks of SDRAM from power-on into a usable state. Software or a reset controller pulses a start input. The block then drives only no-operation commands for a programmable number of clocks, so that the devices can settle. After that it issues the initialization commands for the first rank: one precharge of all banks, eight auto-refresh commands and one mode-register write. Every command lasts a single clock and is followed by a fixed run of no-operation cycles.

When the rank-count input asks for two ranks, the same precharge, refresh and mode-write series is then run a second time with the rank select pointing at the second chip select. The power-up wait is not repeated for the second rank. When the last mode write and its spacing have finished, the block raises a refresh-enable flag and a done flag and holds them until reset.

The value written by the mode write holds the CAS latency together with the derived last-data-to-precharge spacing, which is one less than the latency. The DRAM timing engine, address multiplexing and data path sit outside this block.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted and after its release, the outputs are: command NOP (code 0), rank select 0, done low and refresh-enable low.
- R2: A start pulse in the idle state begins the wait. From the first clock after that pulse, the command is NOP for exactly max(D,1) cycles, where D is the power-up delay input captured with the start pulse. Later changes to the delay input have no effect.
- R3: For each rank the commands come in this order: PRECHARGE-ALL (code 1), eight AUTO-REFRESH (code 2), then MODE-SET (code 3).
- R4: Each command is held for one clock and is followed by exactly GAP_CYC NOP cycles (default 8) before the next command, or before the next phase begins.
- R5: With the two-rank input high at start, the full series from R3 runs again right after the first rank, with rank select 1 and no second power-up wait. The rank select changes to 1 in the same cycle as that rank's PRECHARGE-ALL. With the input low, the rank select stays 0.
- R6: Once the last rank's MODE-SET and its NOP gap have finished, done and refresh-enable go high in the next cycle and the command stays NOP. Both flags stay high until reset, and a later start pulse has no effect.
- R7: A start pulse, or a change of the rank count, delay or CAS latency inputs, while a sequence is running does not change the command, rank, done or mode outputs of that sequence.
- R8: During MODE-SET the mode word carries the CAS latency in bits [6:4] and the latency minus one in bits [2:0], with bits 7 and 3 at zero. The latency is captured at start, and a value below 2 is raised to 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; acted on only in idle |
| two_rank_i | input | 1 | High: initialize two ranks; low: one |
| pwrup_dly_i | input | DLY_W | Power-up NOP wait in clocks |
| cas_lat_i | input | CL_W | CAS latency for the mode word |
| cmd_o | output | 2 | Command: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 mode-set |
| rank_o | output | 1 | Rank (chip select) addressed |
| mode_o | output | MODE_W | Mode word written by MODE-SET |
| refresh_en_o | output | 1 | Auto-refresh enable for normal operation |
| done_o | output | 1 | Initialization complete |

## Verification
A wrong internal state shows up at the command output within one command slot. A refresh counter that is off by one moves the MODE-SET by a full slot of GAP_CYC+1 cycles. A spacing counter that is wrong moves every later command. A rank flag that is wrong either drops the second series or changes the rank select. The bench predicts the command, rank and flags for every cycle after start and compares them cycle by cycle, so each of these faults is reported in the first cycle where the output differs. The bound checker also counts refreshes between precharge and mode write, and it checks that done is sticky and that rank changes line up with precharge.

// File: rtl/sdpu_pkg.sv
package sdpu_pkg;
   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_PREA = 2'd1,
      CMD_AREF = 2'd2,
      CMD_MRS  = 2'd3
   } sdpu_cmd_t;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PWRUP = 3'd1,
      ST_ISSUE = 3'd2,
      ST_GAP   = 3'd3,
      ST_DONE  = 3'd4
   } sdpu_state_t;
endpackage

// File: rtl/sdpu_down_cnt.sv
module sdpu_down_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   input  logic         dec_i,
   output logic         le1_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (ld_i)
         cnt_q <= ld_val_i;
      else if (dec_i && (cnt_q != '0))
         cnt_q <= cnt_q - W'(1);
   end

   assign le1_o = (cnt_q <= W'(1));
endmodule

// File: rtl/sdpu_mode_fmt.sv
module sdpu_mode_fmt #(
   parameter int CL_W   = 3,
   parameter int MODE_W = 8
) (
   input  logic [CL_W-1:0]   cl_i,
   output logic [MODE_W-1:0] mode_o
);
   localparam int CL_LO = CL_W + 1;
   localparam int CL_HI = 2 * CL_W;
   localparam logic [CL_W-1:0] CL_MIN = CL_W'(2);

   logic [CL_W-1:0] cl_eff;

   always_comb begin
      cl_eff = (cl_i < CL_MIN) ? CL_MIN : cl_i;
      mode_o = '0;
      mode_o[CL_HI:CL_LO]  = cl_eff;
      mode_o[CL_W-1:0]     = cl_eff - CL_W'(1);
   end
endmodule

// File: rtl/sdpu_seq_fsm.sv
module sdpu_seq_fsm
   import sdpu_pkg::*;
#(
   parameter int DLY_W     = 16,
   parameter int CL_W      = 3,
   parameter int CNT_W     = 16,
   parameter int GAP_CYC   = 8,
   parameter int MAX_RANKS = 2,
   parameter int AR_NUM    = 8,
   parameter int AR_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             two_rank_i,
   input  logic [DLY_W-1:0] pwrup_dly_i,
   input  logic [CL_W-1:0]  cas_lat_i,
   input  logic             cnt_le1_i,
   output logic             ld_o,
   output logic [CNT_W-1:0] ld_val_o,
   output logic             dec_o,
   output sdpu_cmd_t        cmd_o,
   output logic             rank_o,
   output logic [CL_W-1:0]  cl_o,
   output logic             done_o,
   output logic             ref_en_o
);
   sdpu_state_t     st_q;
   sdpu_cmd_t       nxt_cmd_q;
   logic [AR_W-1:0] ar_cnt_q;
   logic            rank_q;
   logic            two_q;
   logic            mrs_sent_q;
   logic            ref_q;
   logic [CL_W-1:0] cl_q;
   logic            want_two;

   generate
      if (MAX_RANKS >= 2) begin : g_two
         assign want_two = two_rank_i;
      end else begin : g_one
         assign want_two = 1'b0;
      end
   endgenerate

   assign ld_o     = ((st_q == ST_IDLE) && start_i) || (st_q == ST_ISSUE);
   assign ld_val_o = (st_q == ST_IDLE) ? CNT_W'(pwrup_dly_i) : CNT_W'(GAP_CYC);
   assign dec_o    = (st_q == ST_PWRUP) || (st_q == ST_GAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         nxt_cmd_q  <= CMD_PREA;
         ar_cnt_q   <= '0;
         rank_q     <= 1'b0;
         two_q      <= 1'b0;
         mrs_sent_q <= 1'b0;
         ref_q      <= 1'b0;
         cl_q       <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q       <= ST_PWRUP;
                  two_q      <= want_two;
                  cl_q       <= cas_lat_i;
                  rank_q     <= 1'b0;
                  ar_cnt_q   <= '0;
                  nxt_cmd_q  <= CMD_PREA;
                  mrs_sent_q <= 1'b0;
               end
            end
            ST_PWRUP: begin
               if (cnt_le1_i)
                  st_q <= ST_ISSUE;
            end
            ST_ISSUE: begin
               st_q <= ST_GAP;
               case (nxt_cmd_q)
                  CMD_PREA: begin
                     nxt_cmd_q  <= CMD_AREF;
                     ar_cnt_q   <= '0;
                     mrs_sent_q <= 1'b0;
                  end
                  CMD_AREF: begin
                     ar_cnt_q <= ar_cnt_q + AR_W'(1);
                     if (ar_cnt_q == AR_W'(AR_NUM - 1))
                        nxt_cmd_q <= CMD_MRS;
                  end
                  CMD_MRS: begin
                     nxt_cmd_q  <= CMD_PREA;
                     mrs_sent_q <= 1'b1;
                  end
                  default: nxt_cmd_q <= CMD_PREA;
               endcase
            end
            ST_GAP: begin
               if (cnt_le1_i) begin
                  if (!mrs_sent_q) begin
                     st_q <= ST_ISSUE;
                  end else if (two_q && !rank_q) begin
                     rank_q     <= 1'b1;
                     mrs_sent_q <= 1'b0;
                     st_q       <= ST_ISSUE;
                  end else begin
                     st_q  <= ST_DONE;
                     ref_q <= 1'b1;
                  end
               end
            end
            ST_DONE: st_q <= ST_DONE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_o    = (st_q == ST_ISSUE) ? nxt_cmd_q : CMD_NOP;
   assign rank_o   = rank_q;
   assign cl_o     = cl_q;
   assign done_o   = (st_q == ST_DONE);
   assign ref_en_o = ref_q;
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdpu_pkg::*;
#(
   parameter int DLY_W     = 16,
   parameter int CL_W      = 3,
   parameter int MODE_W    = 8,
   parameter int GAP_CYC   = 8,
   parameter int MAX_RANKS = 2,
   parameter int AR_NUM    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              two_rank_i,
   input  logic [DLY_W-1:0]  pwrup_dly_i,
   input  logic [CL_W-1:0]   cas_lat_i,
   output logic [1:0]        cmd_o,
   output logic              rank_o,
   output logic [MODE_W-1:0] mode_o,
   output logic              refresh_en_o,
   output logic              done_o
);
   localparam int GAP_W = $clog2(GAP_CYC + 1);
   localparam int CNT_W = (DLY_W > GAP_W) ? DLY_W : GAP_W;
   localparam int AR_W  = 4;

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (MAX_RANKS < 1 || MAX_RANKS > 2) begin : g_bad_ranks
         $error("MAX_RANKS must be 1 or 2");
      end
      if (MODE_W < 2 * CL_W + 2) begin : g_bad_mode
         $error("MODE_W too narrow for CL_W");
      end
      if (AR_NUM < 1 || AR_NUM >= (1 << AR_W)) begin : g_bad_ar
         $error("AR_NUM does not fit the refresh counter");
      end
   endgenerate

   logic             cnt_ld, cnt_dec, cnt_le1;
   logic [CNT_W-1:0] cnt_val;
   logic [CL_W-1:0]  cl_cap;
   sdpu_cmd_t        cmd_e;

   sdpu_down_cnt #(.W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (cnt_ld),
      .ld_val_i (cnt_val),
      .dec_i    (cnt_dec),
      .le1_o    (cnt_le1)
   );

   sdpu_seq_fsm #(
      .DLY_W(DLY_W), .CL_W(CL_W), .CNT_W(CNT_W), .GAP_CYC(GAP_CYC),
      .MAX_RANKS(MAX_RANKS), .AR_NUM(AR_NUM), .AR_W(AR_W)
   ) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .two_rank_i  (two_rank_i),
      .pwrup_dly_i (pwrup_dly_i),
      .cas_lat_i   (cas_lat_i),
      .cnt_le1_i   (cnt_le1),
      .ld_o        (cnt_ld),
      .ld_val_o    (cnt_val),
      .dec_o       (cnt_dec),
      .cmd_o       (cmd_e),
      .rank_o      (rank_o),
      .cl_o        (cl_cap),
      .done_o      (done_o),
      .ref_en_o    (refresh_en_o)
   );

   sdpu_mode_fmt #(.CL_W(CL_W), .MODE_W(MODE_W)) i_fmt (
      .cl_i   (cl_cap),
      .mode_o (mode_o)
   );

   assign cmd_o = cmd_e;
endmodule

// File: rtl/sdpu_chk.sv
module sdpu_chk #(
   parameter int CL_W   = 3,
   parameter int MODE_W = 8,
   parameter int AR_NUM = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_o,
   input logic              rank_o,
   input logic [MODE_W-1:0] mode_o,
   input logic              refresh_en_o,
   input logic              done_o
);
   logic [4:0] ar_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ar_seen <= '0;
      else if (cmd_o == 2'd1)
         ar_seen <= '0;
      else if (cmd_o == 2'd2 && ar_seen != 5'd31)
         ar_seen <= ar_seen + 5'd1;
   end

   // R3: exactly AR_NUM refreshes between precharge and mode write
   assert_refresh_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd3) |-> (ar_seen == 5'(AR_NUM)));

   // R4: every command lasts one clock
   assert_single_cycle_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != 2'd0) |=> (cmd_o == 2'd0));

   // R5: second rank starts with its precharge
   assert_rank_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rank_o) |-> (cmd_o == 2'd1));

   // R6: done and refresh-enable are sticky, commands stay NOP
   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && refresh_en_o && cmd_o == 2'd0));

   // R8: mode word fields during mode write
   assert_mode_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd3) |-> ((mode_o[2*CL_W:CL_W+1] >= CL_W'(2)) &&
                           (mode_o[CL_W-1:0] == mode_o[2*CL_W:CL_W+1] - CL_W'(1)) &&
                           !mode_o[CL_W]));
endmodule

bind sdram_pwrup_seq sdpu_chk #(.CL_W(CL_W), .MODE_W(MODE_W), .AR_NUM(AR_NUM)) i_sdpu_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_o        (cmd_o),
   .rank_o       (rank_o),
   .mode_o       (mode_o),
   .refresh_en_o (refresh_en_o),
   .done_o       (done_o)
);

// File: tb/test_sdram_pwrup_seq.sv
module test_sdram_pwrup_seq;
   localparam int GAP    = 8;
   localparam int DLY_W  = 16;
   localparam int CL_W   = 3;
   localparam int MODE_W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              two_rank_i = 1'b0;
   logic [DLY_W-1:0]  pwrup_dly_i = '0;
   logic [CL_W-1:0]   cas_lat_i = '0;
   logic [1:0]        cmd_o;
   logic              rank_o;
   logic [MODE_W-1:0] mode_o;
   logic              refresh_en_o;
   logic              done_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sdram_pwrup_seq #(.DLY_W(DLY_W), .CL_W(CL_W), .MODE_W(MODE_W),
                     .GAP_CYC(GAP), .MAX_RANKS(2), .AR_NUM(8)) i_sdram_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .two_rank_i(two_rank_i),
      .pwrup_dly_i(pwrup_dly_i), .cas_lat_i(cas_lat_i), .cmd_o(cmd_o),
      .rank_o(rank_o), .mode_o(mode_o), .refresh_en_o(refresh_en_o), .done_o(done_o)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      // R1: outputs while in reset
      chk("R1", "cmd in reset", cmd_o, 0);
      chk("R1", "done in reset", done_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "cmd after reset", cmd_o, 0);
      chk("R1", "rank after reset", rank_o, 0);
      chk("R1", "done after reset", done_o, 0);
      chk("R1", "refresh_en after reset", refresh_en_o, 0);
   endtask

   // poke: disturb inputs mid-run (R7)
   task automatic run_seq(int dly, bit two, int cl, bit poke);
      int de, nr, per, cle, total;
      de = (dly < 1) ? 1 : dly;
      nr = two ? 2 : 1;
      per = 10 * (GAP + 1);
      cle = (cl < 2) ? 2 : cl;
      total = de + nr * per + 4;
      @(negedge clk);
      start_i = 1'b1;
      pwrup_dly_i = DLY_W'(dly);
      two_rank_i = two;
      cas_lat_i = CL_W'(cl);
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < total; k++) begin
         int ecmd, erank, edone, j, p, slot, off;
         string tag;
         ecmd = 0; erank = 0; edone = 0;
         if (k < de) begin
            tag = "R2";
         end else begin
            j = k - de;
            if (j < nr * per) begin
               erank = j / per;
               p = j % per;
               slot = p / (GAP + 1);
               off = p % (GAP + 1);
               if (off != 0) begin
                  ecmd = 0; tag = "R4";
               end else begin
                  ecmd = (slot == 0) ? 1 : ((slot == 9) ? 3 : 2);
                  tag = "R3";
               end
            end else begin
               edone = 1; tag = "R6";
            end
         end
         if (poke) tag = "R7";
         chk(tag, "cmd", cmd_o, ecmd);
         chk(tag, "done", done_o, edone);
         chk(tag, "refresh_en", refresh_en_o, edone);
         if (!edone) chk(poke ? "R7" : "R5", "rank", rank_o, erank);
         if (ecmd == 3) chk(poke ? "R7" : "R8", "mode word", mode_o, cle * 16 + cle - 1);
         if (poke && k == 3) begin
            start_i = 1'b1;
            two_rank_i = ~two;
            pwrup_dly_i = 16'd999;
            cas_lat_i = 3'd6;
         end else if (poke && k == 4) begin
            start_i = 1'b0;
         end
         @(negedge clk);
      end
   endtask

   task automatic restart_after_done();
      start_i = 1'b1;
      pwrup_dly_i = 16'd2;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 20; k++) begin
         // R6: start ignored once done
         chk("R6", "cmd after done", cmd_o, 0);
         chk("R6", "done held", done_o, 1);
         chk("R6", "refresh_en held", refresh_en_o, 1);
         @(negedge clk);
      end
   endtask

   initial begin
      do_reset();
      run_seq(20, 1'b0, 3, 1'b0);
      restart_after_done();
      do_reset();
      run_seq(5, 1'b1, 2, 1'b0);
      do_reset();
      run_seq(0, 1'b0, 1, 1'b0);
      do_reset();
      run_seq(1, 1'b1, 7, 1'b0);
      do_reset();
      run_seq(12, 1'b1, 4, 1'b1);
      do_reset();
      run_seq(7, 1'b0, 0, 1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule